// File: doc/BRIEF.md
# Charging Relay Safety Supervisor

This block drives the main charging relay of an AC charging station and checks the relay and the supply. It uses two active-low line-sense inputs that are wired downstream of the relay contacts. A third input comes from the ground-fault comparator. The sense pattern means different things depending on the relay command. With the relay commanded open, any line that shows voltage means the contacts are welded. With the relay commanded closed, the pattern tells one live line from two live lines, and no voltage on either line means the ground test has failed.

Each sense line goes through a two-flop synchronizer. A sense check is evaluated only after a settling window that follows every change of the relay command. A sense condition is accepted only once it has been seen for a hold window without a break, so that short dropouts near the AC zero crossings are ignored. Every fault is latched. A latched fault keeps the relay open until a clear is given while no close is being requested. The settling and hold windows are parameters in milliseconds, and the clock frequency is also a parameter.

Top module: `relay_safety_sup`

## Requirements
- R1: `line_a_n` and `line_b_n` read 0 when voltage is present and 1 when it is absent. Each one passes through two flops before any check uses it.
- R2: Out of reset both coil drives are 0, `supply_mode` is 0 and every fault flag is 0. The two coil drives are always equal.
- R3: When `close_req` is 1, no fault is latched and `gf_trip` is 0, both coils go to 1 at the next clock edge. When `close_req` goes to 0, both coils go to 0 at the next clock edge.
- R4: After each change of the coil drive, and after reset, sense checks are skipped for SETTLE_MS worth of cycles.
- R5: A sense condition is acted on only after the same condition has been evaluated on HOLD_MS worth of consecutive cycles. A shorter condition has no effect.
- R6: With the relay open, an accepted pattern that has either sense line at 0 sets `flt_stuck`.
- R7: With the relay closed, an accepted pattern that has exactly one line at 0 sets `supply_mode` to 1. An accepted pattern that has both lines at 0 sets `supply_mode` to 2. `supply_mode` is 0 whenever the coils are 0.
- R8: With the relay closed, an accepted pattern that has both lines at 1 sets `flt_gnd` and opens the relay at the same edge.
- R9: `gf_trip` at 1 on a clock edge sets `flt_gf` and forces both coils to 0 at that edge.
- R10: Fault flags stay set. `clear_req` clears them only while `close_req` is 0. While `close_req` is 1, `clear_req` has no effect.
- R11: While any fault flag is set, `close_req` does not close the relay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| close_req | input | 1 | Request to close the charging relay |
| clear_req | input | 1 | Fault clear, honoured only while close_req is 0 |
| line_a_n | input | 1 | Line A sense, 0 means voltage present (asynchronous) |
| line_b_n | input | 1 | Line B sense, 0 means voltage present (asynchronous) |
| gf_trip | input | 1 | Ground-fault comparator output, 1 means fault (synchronous) |
| coil_a | output | 1 | Relay coil drive A |
| coil_b | output | 1 | Relay coil drive B |
| supply_mode | output | 2 | 0 none, 1 single line, 2 two lines |
| flt_stuck | output | 1 | Latched welded-relay fault |
| flt_gnd | output | 1 | Latched ground-test fault |
| flt_gf | output | 1 | Latched ground fault |

## Verification
A wrong settle or hold counter shows up at the ports as a fault flag or mode change that comes too early or too late. The bench catches it on the exact cycle where the reference model disagrees, because the outputs are compared on every clock. A wrong classification shows up as a wrong `supply_mode` value or a wrong fault flag once the hold window ends. A wrong relay command shows up as a coil mismatch one edge after the input that caused it. Faults that are dropped, or cleared when they should not be, are seen as flags that differ from the model in the cycle after the `clear_req` pulse.

// File: rtl/rsup_pkg.sv
// Shared types for the relay safety supervisor.
// Assumes: nothing beyond the standard language.
package rsup_pkg;
    typedef enum logic [2:0] {
        CLS_OPEN_OK  = 3'd0,
        CLS_STUCK    = 3'd1,
        CLS_GND_FAIL = 3'd2,
        CLS_SINGLE   = 3'd3,
        CLS_DUAL     = 3'd4
    } sense_cls_e;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_DUAL   = 2'd2
    } supply_mode_e;
endpackage

// File: rtl/rsup_sync.sv
// Two-flop synchronizer for a bundle of active-low sense lines.
// Assumes: each bit is independent. Flops reset to 1, which means line absent.
module rsup_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_n,
    output logic [WIDTH-1:0] sync_n
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Pass each line through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b1;
                stab_q[i] <= 1'b1;
            end else begin
                meta_q[i] <= raw_n[i];
                stab_q[i] <= meta_q[i];
            end
        end
    end

    assign sync_n = stab_q;
endmodule

// File: rtl/rsup_settle.sv
// Settling timer: blanks sense evaluation for SETTLE_CYC cycles after each
// change of the relay command, and after reset.
// Assumes: SETTLE_CYC >= 1.
module rsup_settle #(
    parameter int unsigned SETTLE_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_chg,
    output logic active
);
    localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt_q;

    // Reload on a command change, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= CW'(SETTLE_CYC);
        else if (cmd_chg)       cnt_q <= CW'(SETTLE_CYC);
        else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end

    assign active = (cnt_q == '0);

    // R4
    settle_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_chg |=> !active);
endmodule

// File: rtl/rsup_qualify.sv
// Classifies the synchronized sense pattern against the relay command and
// accepts a class only after HOLD_CYC consecutive evaluated cycles.
// Assumes: the sense inputs are already synchronous. HOLD_CYC >= 2.
module rsup_qualify
    import rsup_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       relay_on,
    input  logic       sense_a_n,
    input  logic       sense_b_n,
    output sense_cls_e cls_q,
    output logic       accepted
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);

    sense_cls_e    cls_now;
    logic [HW-1:0] hold_q;

    // Map the sense pattern and the relay command to a class.
    always_comb begin
        if (!relay_on) begin
            cls_now = (sense_a_n && sense_b_n) ? CLS_OPEN_OK : CLS_STUCK;
        end else begin
            case ({sense_a_n, sense_b_n})
                2'b11:   cls_now = CLS_GND_FAIL;
                2'b00:   cls_now = CLS_DUAL;
                default: cls_now = CLS_SINGLE;
            endcase
        end
    end

    // Count consecutive evaluated cycles of one class, restarting on change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q  <= CLS_OPEN_OK;
            hold_q <= '0;
        end else if (!active) begin
            hold_q <= '0;
        end else if (cls_now != cls_q) begin
            cls_q  <= cls_now;
            hold_q <= HW'(1);
        end else if (hold_q != HW'(HOLD_CYC)) begin
            hold_q <= hold_q + HW'(1);
        end
    end

    assign accepted = (hold_q == HW'(HOLD_CYC));

    // R5
    hold_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !accepted);

    // R5
    hold_same_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accepted) |-> $stable(cls_q));
endmodule

// File: rtl/relay_safety_sup.sv
// Charging relay safety supervisor: closes the relay on request, checks for
// welded contacts, detects a one-line or two-line supply, and latches
// ground-test and ground-fault errors.
// Assumes: gf_trip is synchronous to clk. The line-sense pins are asynchronous.
module relay_safety_sup
    import rsup_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned SETTLE_MS = 100,
    parameter int unsigned HOLD_MS   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       close_req,
    input  logic       clear_req,
    input  logic       line_a_n,
    input  logic       line_b_n,
    input  logic       gf_trip,
    output logic       coil_a,
    output logic       coil_b,
    output logic [1:0] supply_mode,
    output logic       flt_stuck,
    output logic       flt_gnd,
    output logic       flt_gf
);
    localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
    localparam int unsigned SETTLE_CYC = CYC_PER_MS * SETTLE_MS;
    localparam int unsigned HOLD_CYC   = CYC_PER_MS * HOLD_MS;
    localparam int unsigned N_COIL     = 2;

    logic [1:0]        sense_n;
    logic              active;
    sense_cls_e        cls_q;
    logic              accepted;
    logic              eval_ok;
    logic              stuck_now;
    logic              gnd_now;
    logic              any_flt;
    logic              clr_ok;
    logic              relay_on;
    logic              relay_nxt;
    logic [N_COIL-1:0] coil_q;
    supply_mode_e      mode_q;

    rsup_sync #(.WIDTH(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  ({line_b_n, line_a_n}),
        .sync_n (sense_n)
    );

    rsup_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_chg (relay_nxt != relay_on),
        .active  (active)
    );

    rsup_qualify #(.HOLD_CYC(HOLD_CYC)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .relay_on  (relay_on),
        .sense_a_n (sense_n[0]),
        .sense_b_n (sense_n[1]),
        .cls_q     (cls_q),
        .accepted  (accepted)
    );

    // Decide the relay command and which faults are detected this cycle.
    always_comb begin
        eval_ok   = active && accepted;
        stuck_now = eval_ok && (cls_q == CLS_STUCK);
        gnd_now   = eval_ok && (cls_q == CLS_GND_FAIL);
        any_flt   = flt_stuck || flt_gnd || flt_gf;
        clr_ok    = clear_req && !close_req;
        relay_nxt = close_req && !any_flt && !gf_trip && !stuck_now && !gnd_now;
    end

    // Drive the two coil flops from the same command.
    for (genvar c = 0; c < N_COIL; c++) begin : g_coil
        always_ff @(posedge clk) begin
            if (!rst_n) coil_q[c] <= 1'b0;
            else        coil_q[c] <= relay_nxt;
        end
    end

    assign relay_on = coil_q[0];
    assign coil_a   = coil_q[0];
    assign coil_b   = coil_q[N_COIL-1];

    // Latch faults. A new detection wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_stuck <= 1'b0;
            flt_gnd   <= 1'b0;
            flt_gf    <= 1'b0;
        end else begin
            flt_stuck <= (flt_stuck && !clr_ok) || stuck_now;
            flt_gnd   <= (flt_gnd   && !clr_ok) || gnd_now;
            flt_gf    <= (flt_gf    && !clr_ok) || gf_trip;
        end
    end

    // Track the supply mode while the relay is closed.
    always_ff @(posedge clk) begin
        if (!rst_n)                               mode_q <= MODE_NONE;
        else if (!relay_nxt)                      mode_q <= MODE_NONE;
        else if (eval_ok && cls_q == CLS_SINGLE)  mode_q <= MODE_SINGLE;
        else if (eval_ok && cls_q == CLS_DUAL)    mode_q <= MODE_DUAL;
    end

    assign supply_mode = mode_q;

    // R9
    gf_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gf_trip |=> (!coil_a && !coil_b && flt_gf));

    // R11
    flt_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stuck || flt_gnd || flt_gf) |-> !coil_a);

    // R7
    mode_needs_coil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_mode != 2'd0) |-> coil_a);

    // R10
    stuck_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flt_stuck) |-> $past(clear_req && !close_req));

    // R10
    gnd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flt_gnd) |-> $past(clear_req && !close_req));
endmodule

// File: tb/relay_safety_sup_bench.sv
// Bench: behavioural reference model compared with the design on every clock.
module relay_safety_sup_bench;
    localparam int SET = 100;
    localparam int HLD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       close_req = 1'b0;
    logic       clear_req = 1'b0;
    logic       line_a_n = 1'b1;
    logic       line_b_n = 1'b1;
    logic       gf_trip = 1'b0;
    logic       coil_a, coil_b, flt_stuck, flt_gnd, flt_gf;
    logic [1:0] supply_mode;

    int compared = 0;
    int mismatched = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    // Model state
    int m_sa1, m_sa2, m_sb1, m_sb2, m_cmd, m_settle, m_cls, m_hold;
    int m_fs, m_fg, m_fgf, m_mode;

    relay_safety_sup #(.CLK_HZ(1000), .SETTLE_MS(SET), .HOLD_MS(HLD)) u_relay_safety_sup (
        .clk(clk), .rst_n(rst_n), .close_req(close_req), .clear_req(clear_req),
        .line_a_n(line_a_n), .line_b_n(line_b_n), .gf_trip(gf_trip),
        .coil_a(coil_a), .coil_b(coil_b), .supply_mode(supply_mode),
        .flt_stuck(flt_stuck), .flt_gnd(flt_gnd), .flt_gf(flt_gf)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, classes: 0 open ok, 1 stuck, 2 ground fail, 3 single, 4 dual
    always @(posedge clk) begin
        int act, cls, acc, fs_new, fg_new, cmdn, clr;
        if (!rst_n) begin
            m_sa1 = 1; m_sa2 = 1; m_sb1 = 1; m_sb2 = 1; m_cmd = 0; m_settle = SET;
            m_cls = 0; m_hold = 0; m_fs = 0; m_fg = 0; m_fgf = 0; m_mode = 0;
        end else begin
            act = (m_settle == 0);
            if (m_cmd == 0) cls = (m_sa2 == 1 && m_sb2 == 1) ? 0 : 1;
            else if (m_sa2 == 1 && m_sb2 == 1) cls = 2;
            else if (m_sa2 == 0 && m_sb2 == 0) cls = 4;
            else cls = 3;
            acc = act && (m_hold == HLD);
            fs_new = acc && (m_cls == 1);
            fg_new = acc && (m_cls == 2);
            clr = clear_req && !close_req;
            cmdn = close_req && !(m_fs || m_fg || m_fgf) && !gf_trip && !fs_new && !fg_new;
            m_fs  = (m_fs && !clr) || fs_new;
            m_fg  = (m_fg && !clr) || fg_new;
            m_fgf = (m_fgf && !clr) || gf_trip;
            if (!cmdn) m_mode = 0;
            else if (acc && m_cls == 3) m_mode = 1;
            else if (acc && m_cls == 4) m_mode = 2;
            if (cmdn != m_cmd) m_settle = SET;
            else if (m_settle > 0) m_settle = m_settle - 1;
            if (!act) m_hold = 0;
            else if (cls != m_cls) begin m_cls = cls; m_hold = 1; end
            else if (m_hold < HLD) m_hold = m_hold + 1;
            m_cmd = cmdn;
            m_sa2 = m_sa1; m_sa1 = line_a_n;
            m_sb2 = m_sb1; m_sb1 = line_b_n;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (running && !done) begin
            chk("R3 coil_a", coil_a, m_cmd);
            chk("R2 coil_b", coil_b, m_cmd);
            chk("R7 supply_mode", supply_mode, m_mode);
            chk("R6 flt_stuck", flt_stuck, m_fs);
            chk("R8 flt_gnd", flt_gnd, m_fg);
            chk("R9 flt_gf", flt_gf, m_fgf);
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        wait_cyc(4);
        rst_n = 1'b1;
        running = 1'b1;
        wait_cyc(1);
        // R2: reset state
        chk("R2 reset coil", coil_a | coil_b, 0);
        chk("R2 reset mode", supply_mode, 0);
        chk("R2 reset flags", flt_stuck | flt_gnd | flt_gf, 0);
        wait_cyc(SET + 5);

        // R3: close takes effect one edge later
        close_req = 1'b1; line_a_n = 1'b0;
        wait_cyc(1);
        chk("R3 close edge", coil_a, 1);
        // R1 R7: single line after sync, settle and hold
        wait_cyc(SET + HLD + 6);
        chk("R1 R7 single mode", supply_mode, 1);

        // R5: short dropout of both lines is ignored
        line_a_n = 1'b1;
        wait_cyc(HLD / 2);
        line_a_n = 1'b0;
        wait_cyc(HLD + 5);
        chk("R5 dropout ignored gnd", flt_gnd, 0);
        chk("R5 dropout coil", coil_a, 1);

        // R7: two lines
        line_b_n = 1'b0;
        wait_cyc(HLD + 5);
        chk("R7 dual mode", supply_mode, 2);

        // R4: lines stay live inside the settle window after opening
        close_req = 1'b0;
        wait_cyc(1);
        chk("R3 open edge", coil_a, 0);
        chk("R7 mode cleared on open", supply_mode, 0);
        wait_cyc(SET - 40);
        line_a_n = 1'b1; line_b_n = 1'b1;
        wait_cyc(SET + HLD);
        chk("R4 settle blanks stuck", flt_stuck, 0);

        // R6: welded relay seen while open
        line_a_n = 1'b0;
        wait_cyc(HLD + 6);
        chk("R6 stuck detected", flt_stuck, 1);
        line_a_n = 1'b1;

        // R11: close refused while faulted
        close_req = 1'b1;
        wait_cyc(10);
        chk("R11 close blocked", coil_a, 0);

        // R10: clear ignored while close requested, honoured otherwise
        clear_req = 1'b1;
        wait_cyc(2);
        chk("R10 clear ignored", flt_stuck, 1);
        close_req = 1'b0;
        wait_cyc(2);
        clear_req = 1'b0;
        chk("R10 clear honoured", flt_stuck, 0);
        wait_cyc(5);

        // R8: ground test failure while closed
        close_req = 1'b1;
        wait_cyc(SET + HLD + 6);
        chk("R8 ground fail flag", flt_gnd, 1);
        chk("R8 relay opened", coil_a, 0);
        close_req = 1'b0;
        clear_req = 1'b1;
        wait_cyc(2);
        clear_req = 1'b0;
        wait_cyc(SET + 5);

        // R9: ground fault opens relay at once
        close_req = 1'b1; line_a_n = 1'b0;
        wait_cyc(SET + HLD + 6);
        chk("R9 pre trip coil", coil_a, 1);
        gf_trip = 1'b1;
        wait_cyc(1);
        gf_trip = 1'b0;
        chk("R9 coil opened", coil_a | coil_b, 0);
        chk("R9 flag set", flt_gf, 1);
        wait_cyc(20);
        chk("R9 flag sticky", flt_gf, 1);
        close_req = 1'b0;
        wait_cyc(5);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule